// File: doc/BRIEF.md
# Fixed-Point Load Execute Unit

This unit carries out the execute step of a 64-bit integer load that has already been decoded. The issue side gives it an operation code, the destination and base register indices, the base register value and a 16-bit displacement. The unit forms the effective address and the access width, then presents a read request to data memory with a valid/ready handshake. When read data comes back, it builds the 64-bit destination value by zero-extension or sign-extension. Update forms also write the effective address back to the base register.

Only one load is in flight at a time. `issue_ready` is high only while the unit is idle. Read data arrives on a 64-bit bus in big-endian order. The requested item sits in the low-order bytes of the bus, with its first memory byte as the most significant byte of the item. The unit treats the bus bytes above the item as don't-care. An update form that names register 0 as its base, or that uses the same register for base and destination, is rejected. The unit then raises a one-cycle illegal flag and issues no memory request and no writeback.

Top module: `fxload_unit`

## Requirements
- R1: For a non-update operation with `issue_ra` equal to 0, the base is 0 and `issue_base` is ignored. For any other `issue_ra`, the base is `issue_base`.
- R2: Update operations always add the displacement to `issue_base`.
- R3: For word-signed (op 8), doubleword (op 9) and doubleword-update (op 10), the offset is the sign extension of `{issue_disp[15:2], 2'b00}`. Displacement bits [1:0] have no effect.
- R4: All other operations use the sign extension of all 16 displacement bits as the offset. The effective address is the base plus the offset, modulo 2^64.
- R5: Op codes are 0 byte-zero, 1 byte-zero-update, 2 half-zero, 3 half-zero-update, 4 half-signed, 5 half-signed-update, 6 word-zero, 7 word-zero-update, 8 word-signed, 9 doubleword and 10 doubleword-update. `mem_size` gives the access width in bytes (1, 2, 4 or 8).
- R6: Zero-extending loads return the low 1, 2 or 4 bus bytes with all upper result bits cleared.
- R7: Half-signed and word-signed loads copy bit 15 or bit 31 of the item into every higher result bit.
- R8: Doubleword loads return all 64 bus bits unchanged.
- R9: A legal update operation raises `upd_valid` in the same cycle as `res_valid`, with `upd_ra` set to the base index and `upd_data` set to the effective address. Non-update operations never raise `upd_valid`.
- R10: Op codes 11 to 15, and update operations with base index 0 or with base index equal to destination index, raise `illegal` for one cycle, start no memory request and produce no `res_valid` or `upd_valid`.
- R11: `mem_req_valid` holds, with a stable `mem_addr`, until `mem_req_ready` is seen. `res_valid` pulses for exactly one cycle, the cycle after `mem_rsp_valid` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | A decoded load is offered |
| issue_ready | output | 1 | Unit idle, will accept a load |
| issue_op | input | 4 | Load operation code (R5) |
| issue_rt | input | 5 | Destination register index |
| issue_ra | input | 5 | Base register index |
| issue_base | input | 64 | Base register contents |
| issue_disp | input | 16 | Signed displacement field |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 64 | Effective byte address |
| mem_size | output | 4 | Access width in bytes |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, item in low-order bytes |
| res_valid | output | 1 | Destination writeback strobe |
| res_rt | output | 5 | Destination register index |
| res_data | output | 64 | Extended load result |
| upd_valid | output | 1 | Base writeback strobe |
| upd_ra | output | 5 | Base register index to update |
| upd_data | output | 64 | Effective address for base update |
| illegal | output | 1 | Invalid form flag pulse |

## Verification
The bench targets the cases where these operations differ. A non-update load with base index 0 gets a nonzero base value, so an adder that never zeroes the base lands on the wrong address. Halfword and word signed loads are run with the top item bit both set and clear, and the bus bytes above the item are filled with junk. A bad mask or a wrong sign source shows up as wrong upper result bits. Doubleword loads use the largest positive and negative word-scaled offsets, with the two low displacement bits set, so that unscaled or unmasked offsets give the wrong address. Illegal update forms must produce neither a request nor a writeback.

// File: rtl/fxload_pkg.sv
// Shared types for the fixed-point load execute unit.
// Assumes op codes as listed in the brief; unknown codes decode as not known.
package fxload_pkg;

    localparam int XLEN  = 64;
    localparam int REGW  = 5;
    localparam int DISPW = 16;
    localparam int SIZEW = 4;

    typedef enum logic [3:0] {
        OP_BZ  = 4'd0,  OP_BZU = 4'd1,
        OP_HZ  = 4'd2,  OP_HZU = 4'd3,
        OP_HS  = 4'd4,  OP_HSU = 4'd5,
        OP_WZ  = 4'd6,  OP_WZU = 4'd7,
        OP_WS  = 4'd8,
        OP_DW  = 4'd9,  OP_DWU = 4'd10
    } ld_op_e;

    typedef struct packed {
        logic [SIZEW-1:0] nbytes;  // access width in bytes
        logic             sgn;     // sign-extend result
        logic             upd;     // base writeback form
        logic             wscale;  // word-scaled displacement
        logic             known;   // legal op code
    } ld_attr_t;

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} ld_state_e;

    // Maps an op code to its access attributes.
    function automatic ld_attr_t op_attr(logic [3:0] op);
        ld_attr_t a;
        a = '{nbytes: 4'd0, sgn: 1'b0, upd: 1'b0, wscale: 1'b0, known: 1'b1};
        case (op)
            OP_BZ:  a.nbytes = 4'd1;
            OP_BZU: begin a.nbytes = 4'd1; a.upd = 1'b1; end
            OP_HZ:  a.nbytes = 4'd2;
            OP_HZU: begin a.nbytes = 4'd2; a.upd = 1'b1; end
            OP_HS:  begin a.nbytes = 4'd2; a.sgn = 1'b1; end
            OP_HSU: begin a.nbytes = 4'd2; a.sgn = 1'b1; a.upd = 1'b1; end
            OP_WZ:  a.nbytes = 4'd4;
            OP_WZU: begin a.nbytes = 4'd4; a.upd = 1'b1; end
            OP_WS:  begin a.nbytes = 4'd4; a.sgn = 1'b1; a.wscale = 1'b1; end
            OP_DW:  begin a.nbytes = 4'd8; a.wscale = 1'b1; end
            OP_DWU: begin a.nbytes = 4'd8; a.wscale = 1'b1; a.upd = 1'b1; end
            default: a.known = 1'b0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/fxload_agen.sv
// Address generation and form check for one decoded load.
// Purely combinational; assumes the attributes come from op_attr.
module fxload_agen
    import fxload_pkg::*;
#(
    parameter int AW = XLEN,
    parameter int RW = REGW,
    parameter int DW = DISPW
) (
    input  ld_attr_t          attr,
    input  logic [RW-1:0]     ra,
    input  logic [RW-1:0]     rt,
    input  logic [AW-1:0]     base,
    input  logic [DW-1:0]     disp,
    output logic [AW-1:0]     ea,
    output logic              bad_form
);
    localparam int EXTW = AW - DW;

    logic [AW-1:0] base_sel;
    logic [AW-1:0] offset;
    logic [DW-1:0] disp_eff;

    // Choose the base: literal zero for index 0 unless an update form.
    always_comb begin
        base_sel = (!attr.upd && ra == '0) ? '0 : base;
    end

    // Word-scaled forms drop the two low displacement bits.
    always_comb begin
        disp_eff = attr.wscale ? {disp[DW-1:2], 2'b00} : disp;
        offset   = {{EXTW{disp_eff[DW-1]}}, disp_eff};
        ea       = base_sel + offset;
    end

    // Reject unknown codes and update forms that would clash on writeback.
    always_comb begin
        bad_form = !attr.known || (attr.upd && (ra == '0 || ra == rt));
    end
endmodule

// File: rtl/fxload_extend.sv
// Result extension: keeps the low item bytes of the read bus and fills
// the rest with zeros or the item's top bit. Assumes nbytes is 1, 2, 4 or 8.
module fxload_extend
    import fxload_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [SIZEW-1:0] nbytes,
    input  logic             sgn,
    input  logic [W-1:0]     rdata,
    output logic [W-1:0]     result
);
    // Width-selected zero or sign extension.
    always_comb begin
        case (nbytes)
            4'd1:    result = {{(W-8){sgn & rdata[7]}},   rdata[7:0]};
            4'd2:    result = {{(W-16){sgn & rdata[15]}}, rdata[15:0]};
            4'd4:    result = {{(W-32){sgn & rdata[31]}}, rdata[31:0]};
            default: result = rdata;
        endcase
    end
endmodule

// File: rtl/fxload_unit.sv
// Fixed-point load execute unit: accepts one decoded load, issues a read,
// and on return raises destination and (for update forms) base writebacks.
// Assumes one load in flight; read data only accepted while waiting.
module fxload_unit
    import fxload_pkg::*;
#(
    parameter int AW = XLEN,
    parameter int RW = REGW,
    parameter int DW = DISPW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_valid,
    output logic          issue_ready,
    input  logic [3:0]    issue_op,
    input  logic [RW-1:0] issue_rt,
    input  logic [RW-1:0] issue_ra,
    input  logic [AW-1:0] issue_base,
    input  logic [DW-1:0] issue_disp,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_size,
    input  logic          mem_rsp_valid,
    input  logic [AW-1:0] mem_rsp_data,
    output logic          res_valid,
    output logic [RW-1:0] res_rt,
    output logic [AW-1:0] res_data,
    output logic          upd_valid,
    output logic [RW-1:0] upd_ra,
    output logic [AW-1:0] upd_data,
    output logic          illegal
);
    ld_state_e     state;
    ld_attr_t      attr, q_attr;
    logic [AW-1:0] ea, q_ea, ext_data;
    logic [RW-1:0] q_rt, q_ra;
    logic          bad_form, fire, rsp_take;

    assign attr        = op_attr(issue_op);
    assign issue_ready = (state == ST_IDLE);
    assign fire        = issue_valid && issue_ready;
    assign rsp_take    = (state == ST_WAIT) && mem_rsp_valid;

    fxload_agen #(.AW(AW), .RW(RW), .DW(DW)) u_agen (
        .attr(attr), .ra(issue_ra), .rt(issue_rt), .base(issue_base),
        .disp(issue_disp), .ea(ea), .bad_form(bad_form)
    );

    fxload_extend #(.W(AW)) u_ext (
        .nbytes(q_attr.nbytes), .sgn(q_attr.sgn), .rdata(mem_rsp_data),
        .result(ext_data)
    );

    // Request stage outputs come straight from the captured load.
    assign mem_req_valid = (state == ST_REQ);
    assign mem_addr      = q_ea;
    assign mem_size      = q_attr.nbytes;

    // Sequencer: idle -> request -> wait for data -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (fire && !bad_form) state <= ST_REQ;
                ST_REQ:  if (mem_req_ready)     state <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid)     state <= ST_IDLE;
                default:                        state <= ST_IDLE;
            endcase
        end
    end

    // Capture the accepted load's address and attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_attr <= '0;
            q_ea   <= '0;
            q_rt   <= '0;
            q_ra   <= '0;
        end else if (fire) begin
            q_attr <= attr;
            q_ea   <= ea;
            q_rt   <= issue_rt;
            q_ra   <= issue_ra;
        end
    end

    // One-cycle writeback strobes and illegal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            upd_valid <= 1'b0;
            illegal   <= 1'b0;
            res_rt    <= '0;
            res_data  <= '0;
            upd_ra    <= '0;
            upd_data  <= '0;
        end else begin
            res_valid <= rsp_take;
            upd_valid <= rsp_take && q_attr.upd;
            illegal   <= fire && bad_form;
            if (rsp_take) begin
                res_rt   <= q_rt;
                res_data <= ext_data;
                upd_ra   <= q_ra;
                upd_data <= q_ea;
            end
        end
    end

    // R11
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));

    // R9
    upd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (res_valid && upd_data == mem_addr));

    // R10
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!res_valid && !upd_valid && !mem_req_valid));

    // R5
    size_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> $onehot(mem_size));
endmodule

// File: tb/sim_fxload_unit.sv
`timescale 1ns/1ps
module sim_fxload_unit;
    typedef struct packed {
        logic [3:0]  op;
        logic [4:0]  rt;
        logic [4:0]  ra;
        logic [63:0] base;
        logic [15:0] disp;
        logic [63:0] ea;
        logic        ill;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{4'd0,  5'd3, 5'd0, 64'h1234,  16'h0040, 64'h40,   1'b0}, // R1 base forced 0
        '{4'd0,  5'd3, 5'd5, 64'h1000,  16'hFFF0, 64'hFF0,  1'b0}, // R4 negative
        '{4'd2,  5'd4, 5'd6, 64'h100,   16'h0044, 64'h144,  1'b0}, // R6
        '{4'd4,  5'd4, 5'd6, 64'h100,   16'h0044, 64'h144,  1'b0}, // R7 sign set
        '{4'd4,  5'd4, 5'd6, 64'h100,   16'h0040, 64'h140,  1'b0}, // R7 sign clear
        '{4'd6,  5'd7, 5'd8, 64'h2000,  16'h0042, 64'h2042, 1'b0}, // R4 odd offset
        '{4'd8,  5'd7, 5'd8, 64'h2000,  16'h0046, 64'h2044, 1'b0}, // R3 low bits dropped
        '{4'd8,  5'd7, 5'd8, 64'h2000,  16'h0040, 64'h2040, 1'b0}, // R7 word sign clear
        '{4'd9,  5'd9, 5'd0, 64'hFFFF,  16'h7FFF, 64'h7FFC, 1'b0}, // R1 R3 max positive
        '{4'd9,  5'd9, 5'd2, 64'h10000, 16'h8003, 64'h8000, 1'b0}, // R3 max negative
        '{4'd1,  5'd1, 5'd2, 64'h500,   16'hFFFF, 64'h4FF,  1'b0}, // R2 R9
        '{4'd3,  5'd1, 5'd2, 64'h500,   16'h0010, 64'h510,  1'b0}, // R9
        '{4'd5,  5'd1, 5'd2, 64'h500,   16'h0044, 64'h544,  1'b0}, // R9
        '{4'd7,  5'd1, 5'd2, 64'h500,   16'h0008, 64'h508,  1'b0}, // R9
        '{4'd10, 5'd1, 5'd2, 64'h500,   16'hFFFB, 64'h4F8,  1'b0}, // R3 R9
        '{4'd1,  5'd1, 5'd0, 64'h500,   16'h0004, 64'h0,    1'b1}, // R10 base 0
        '{4'd10, 5'd3, 5'd3, 64'h500,   16'h0004, 64'h0,    1'b1}, // R10 base==dest
        '{4'd15, 5'd3, 5'd4, 64'h500,   16'h0004, 64'h0,    1'b1}  // R10 unknown op
    };

    logic clk = 0, rst_n = 0;
    logic issue_valid = 0, issue_ready;
    logic [3:0] issue_op = 0;
    logic [4:0] issue_rt = 0, issue_ra = 0;
    logic [63:0] issue_base = 0;
    logic [15:0] issue_disp = 0;
    logic mem_req_valid, mem_req_ready = 0;
    logic [63:0] mem_addr;
    logic [3:0] mem_size;
    logic mem_rsp_valid = 0;
    logic [63:0] mem_rsp_data = 0;
    logic res_valid, upd_valid, illegal;
    logic [4:0] res_rt, upd_ra;
    logic [63:0] res_data, upd_data;

    int checks = 0, failures = 0;
    logic [7:0] mem [256];

    always #4 clk = ~clk;

    fxload_unit u0 (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int op_bytes(input logic [3:0] op);
        case (op)
            0, 1: return 1;
            2, 3, 4, 5: return 2;
            6, 7, 8: return 4;
            default: return 8;
        endcase
    endfunction

    function automatic bit op_signed(input logic [3:0] op);
        return op == 4 || op == 5 || op == 8;
    endfunction

    // Big-endian item read from the byte memory.
    function automatic logic [63:0] raw_item(input logic [63:0] ea, input int n);
        logic [63:0] v = 0;
        for (int i = 0; i < n; i++) v = (v << 8) | 64'(mem[8'(ea[7:0] + i)]);
        return v;
    endfunction

    function automatic logic [63:0] expect_res(input logic [3:0] op, input logic [63:0] ea);
        int n = op_bytes(op);
        logic [63:0] v = raw_item(ea, n);
        if (op_signed(op) && n == 2) v = {{48{v[15]}}, v[15:0]};
        if (op_signed(op) && n == 4) v = {{32{v[31]}}, v[31:0]};
        return v;
    endfunction

    task automatic run_vec(input vec_t v);
        int n;
        logic [63:0] bus;
        bit upd;
        @(negedge clk);
        issue_valid = 1; issue_op = v.op; issue_rt = v.rt; issue_ra = v.ra;
        issue_base = v.base; issue_disp = v.disp;
        @(negedge clk);
        issue_valid = 0;
        if (v.ill) begin
            check(illegal === 1'b1, "R10 illegal flag", 64'(illegal), 1);
            for (int k = 0; k < 3; k++) begin
                check(!mem_req_valid && !res_valid && !upd_valid, "R10 no activity",
                      {61'b0, mem_req_valid, res_valid, upd_valid}, 0);
                @(negedge clk);
            end
            check(illegal === 1'b0, "R10 flag one cycle", 64'(illegal), 0);
            return;
        end
        n = op_bytes(v.op);
        upd = v.op inside {4'd1, 4'd3, 4'd5, 4'd7, 4'd10};
        check(mem_req_valid === 1'b1, "R11 request", 64'(mem_req_valid), 1);
        check(mem_addr === v.ea, "R1 R2 R3 R4 address", mem_addr, v.ea);
        check(mem_size === 4'(n), "R5 size", 64'(mem_size), 64'(n));
        @(negedge clk);
        check(mem_req_valid === 1'b1 && mem_addr === v.ea, "R11 hold", mem_addr, v.ea);
        mem_req_ready = 1;
        @(negedge clk);
        mem_req_ready = 0;
        check(mem_req_valid === 1'b0, "R11 request drops", 64'(mem_req_valid), 0);
        bus = {8{8'hA5}};
        for (int i = 0; i < n; i++) bus[8*i +: 8] = mem[8'(v.ea[7:0] + n - 1 - i)];
        mem_rsp_valid = 1; mem_rsp_data = bus;
        @(negedge clk);
        mem_rsp_valid = 0; mem_rsp_data = '1;
        check(res_valid === 1'b1 && res_rt === v.rt, "R11 result strobe",
              {58'b0, res_valid, res_rt}, {58'b0, 1'b1, v.rt});
        check(res_data === expect_res(v.op, v.ea), "R6 R7 R8 result data",
              res_data, expect_res(v.op, v.ea));
        check(upd_valid === upd, "R9 update strobe", 64'(upd_valid), 64'(upd));
        if (upd)
            check(upd_ra === v.ra && upd_data === v.ea, "R9 update value", upd_data, v.ea);
        @(negedge clk);
        check(!res_valid && !upd_valid, "R11 one-cycle pulse",
              {62'b0, res_valid, upd_valid}, 0);
    endtask

    initial begin
        #(8ns * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 8'h9D + 8'h13);
        mem[8'h40] = 8'h7F; mem[8'h44] = 8'h80;
        repeat (3) @(negedge clk);
        check(issue_ready && !mem_req_valid && !res_valid && !upd_valid && !illegal,
              "R11 reset state", {59'b0, issue_ready, mem_req_valid, res_valid, upd_valid, illegal},
              64'h10);
        rst_n = 1;
        for (int i = 0; i < NV; i++) run_vec(VEC[i]);
        // R8 doubleword with every byte's top bit set must pass unchanged
        for (int i = 0; i < 8; i++) mem[8'h80 + i] = 8'hF0 | 8'(i);
        run_vec('{4'd9, 5'd6, 5'd7, 64'h80, 16'h0000, 64'h80, 1'b0});
        // R1 nonzero base index with zero base value still adds
        run_vec('{4'd2, 5'd6, 5'd7, 64'h0, 16'h0030, 64'h30, 1'b0});
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule